// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Datapath

This block computes running sums of products for filter loops. Each cycle it can accept one coefficient and one sample, both signed two's complement fixed-point words of `DATA_W` bits. It multiplies them into a full-width product register. It then adds that product to, or subtracts it from, a wide accumulator. The accumulator has `2*DATA_W` bits plus `GUARD_W` overflow guard bits. A final stage scales the accumulator back to a `DATA_W`-bit word: it applies an arithmetic right shift, optional rounding and saturation. The result therefore has the same type as the operands.

The controls travel down the pipeline with their operand pair, so each operation carries its own controls. Those controls are: start a new sum, subtract, fractional alignment, shift amount and rounding mode. A result appears three cycles after every accepted operand pair and reflects the accumulator after that operation. Setting the start bit on the first tap of a new output lets filter outputs follow each other with no idle cycle. Because the binary point is only a convention of the caller, one datapath serves integer, mixed and purely fractional formats.

Top module: `fxp_mac`

## Requirements
- R1: A new operand pair is accepted on every cycle that `in_valid` is high, with no stall. `out_valid` pulses exactly three clock edges later, once for each accepted pair.
- R2: The product of the two operands is exact. With shift 0 and truncation, a single small product appears unchanged at the output, for example 3 times 4 gives 12 and 100 times -7 gives -700.
- R3: When `in_clear` is high, the accumulator is loaded with the operation's own signed product and the previous sum is discarded. Without it, the product is combined with the previous sum.
- R4: When `in_sub` is high, the product is subtracted from the accumulator instead of added.
- R5: The accumulator is `2*DATA_W+GUARD_W` bits wide. With the defaults of 16 and 8, 200 products of -32768 times -32768 sum to 200*2^30 without wrapping, and a shift of 24 yields 12800.
- R6: When `in_frac` is high, the product is doubled (shifted left by one) before it enters the accumulator. For example, 0x4000 times 0x4000 with a shift of 16 yields 0x2000.
- R7: With `in_round` low, the result is the accumulator arithmetically shifted right by `in_shift` (0 to `2*DATA_W+GUARD_W-1`), which rounds toward minus infinity. For example, an accumulator of -3 shifted by 1 yields -2.
- R8: With `in_round` high and a nonzero shift, one half of the result's LSB is added before shifting (round half up). For example, 3 shifted by 1 yields 2 and -3 shifted by 1 yields -1. With a shift of 0, rounding has no effect.
- R9: A scaled value above the largest `DATA_W`-bit signed number yields 0x7FFF (for 16 bits). A value below the smallest yields 0x8000.
- R10: In a cycle where `in_valid` is low, all other inputs are ignored: the accumulator keeps its value and no result is produced for that cycle.
- R11: After a synchronous reset, `out_valid` and `out_data` are 0 and the accumulator holds 0. An operation without `in_clear` then starts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair and controls are valid this cycle |
| in_coef | input | DATA_W | Signed coefficient |
| in_samp | input | DATA_W | Signed sample |
| in_clear | input | 1 | Start a new sum with this product |
| in_sub | input | 1 | Subtract the product instead of adding it |
| in_frac | input | 1 | Double the product (fractional operand alignment) |
| in_shift | input | $clog2(2*DATA_W+GUARD_W) | Right shift applied to the accumulator for this result |
| in_round | input | 1 | 1 = round half up, 0 = truncate |
| out_valid | output | 1 | A scaled result is present |
| out_data | output | DATA_W | Scaled, saturated result |

## Verification
The bench targets several boundaries where a faulty design fails in a recognisable way. A long run of the largest positive product exposes an accumulator without guard bits, which would wrap to a negative total. Negative odd sums scaled by one bit separate flooring from rounding toward zero, and round-half-up from plain truncation. Products at the extreme operand codes show whether saturation picks the correct rail or simply keeps the low bits. Start-of-sum, subtract and fractional doubling are mixed into random back-to-back streams with idle gaps. A control that reached the wrong pipeline stage, or an accumulator that changed during an idle cycle, would then corrupt a later result.

// File: rtl/fxp_mac_pkg.sv
package fxp_mac_pkg;

    // Per-operation controls that ride alongside the operand pair
    typedef struct packed {
        logic start;   // begin a new sum with this product
        logic neg;     // subtract instead of add
        logic dbl;     // fractional alignment: double the product
        logic rnd;     // round half up at the output stage
    } mac_op_t;

    typedef enum logic {
        SCALE_FLOOR   = 1'b0,
        SCALE_HALF_UP = 1'b1
    } scale_mode_e;

    localparam int DEF_DATA_W  = 16;
    localparam int DEF_GUARD_W = 8;

    function automatic scale_mode_e mode_of(input mac_op_t op);
        return op.rnd ? SCALE_HALF_UP : SCALE_FLOOR;
    endfunction

endpackage

// File: rtl/fxp_mac_mul.sv
module fxp_mac_mul
    import fxp_mac_pkg::*;
#(
    parameter int DATA_W  = DEF_DATA_W,
    parameter int SHIFT_W = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  a_valid,
    input  logic [DATA_W-1:0]     a_coef,
    input  logic [DATA_W-1:0]     a_samp,
    input  mac_op_t               a_op,
    input  logic [SHIFT_W-1:0]    a_shift,
    output logic                  p_valid,
    output logic [2*DATA_W-1:0]   p_prod,
    output mac_op_t               p_op,
    output logic [SHIFT_W-1:0]    p_shift
);
    localparam int PROD_W = 2 * DATA_W;

    logic signed [PROD_W-1:0] prod_d;

    always_comb begin
        prod_d = PROD_W'($signed(a_coef) * $signed(a_samp));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p_valid <= 1'b0;
            p_prod  <= '0;
            p_op    <= '0;
            p_shift <= '0;
        end else begin
            p_valid <= a_valid;
            if (a_valid) begin
                p_prod  <= prod_d;
                p_op    <= a_op;
                p_shift <= a_shift;
            end
        end
    end

    p_issue_r1: assert property (@(posedge clk) disable iff (rst)
        a_valid |=> p_valid);
    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !a_valid |=> !p_valid);

endmodule

// File: rtl/fxp_mac_acc.sv
module fxp_mac_acc
    import fxp_mac_pkg::*;
#(
    parameter int DATA_W  = DEF_DATA_W,
    parameter int GUARD_W = DEF_GUARD_W,
    parameter int SHIFT_W = 6
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                p_valid,
    input  logic [2*DATA_W-1:0]                 p_prod,
    input  mac_op_t                             p_op,
    input  logic [SHIFT_W-1:0]                  p_shift,
    output logic                                s_valid,
    output logic [2*DATA_W+GUARD_W-1:0]         s_acc,
    output logic [SHIFT_W-1:0]                  s_shift,
    output scale_mode_e                         s_mode
);
    localparam int PROD_W = 2 * DATA_W;
    localparam int ACC_W  = PROD_W + GUARD_W;
    localparam int EXT_W  = ACC_W - PROD_W;

    logic signed [ACC_W-1:0] prod_ext;
    logic signed [ACC_W-1:0] addend;
    logic signed [ACC_W-1:0] base;
    logic signed [ACC_W-1:0] acc_d;

    always_comb begin
        prod_ext = {{EXT_W{p_prod[PROD_W-1]}}, p_prod};
        addend   = p_op.dbl ? (prod_ext <<< 1) : prod_ext;
        base     = p_op.start ? '0 : $signed(s_acc);
        acc_d    = p_op.neg ? (base - addend) : (base + addend);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_valid <= 1'b0;
            s_acc   <= '0;
            s_shift <= '0;
            s_mode  <= SCALE_FLOOR;
        end else begin
            s_valid <= p_valid;
            if (p_valid) begin
                s_acc   <= acc_d;
                s_shift <= p_shift;
                s_mode  <= mode_of(p_op);
            end
        end
    end

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !p_valid |=> $stable(s_acc));
    p_fresh_sum_r3: assert property (@(posedge clk) disable iff (rst)
        (p_valid && p_op.start && !p_op.neg && !p_op.dbl)
        |=> (s_acc[PROD_W-1:0] == $past(p_prod)));

endmodule

// File: rtl/fxp_mac_scale.sv
module fxp_mac_scale
    import fxp_mac_pkg::*;
#(
    parameter int DATA_W  = DEF_DATA_W,
    parameter int GUARD_W = DEF_GUARD_W,
    parameter int SHIFT_W = 6
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          s_valid,
    input  logic [2*DATA_W+GUARD_W-1:0]   s_acc,
    input  logic [SHIFT_W-1:0]            s_shift,
    input  scale_mode_e                   s_mode,
    output logic                          o_valid,
    output logic [DATA_W-1:0]             o_data
);
    localparam int ACC_W = 2 * DATA_W + GUARD_W;
    localparam int EXT_W = ACC_W + 1;
    localparam logic signed [EXT_W-1:0] TOP_V =
        {{(EXT_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [EXT_W-1:0] BOT_V =
        {{(EXT_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

    logic signed [EXT_W-1:0] widened;
    logic signed [EXT_W-1:0] half_lsb;
    logic signed [EXT_W-1:0] biased;
    logic signed [EXT_W-1:0] scaled;
    logic        [DATA_W-1:0] clipped;

    always_comb begin
        widened  = {s_acc[ACC_W-1], s_acc};
        half_lsb = '0;
        if (s_mode == SCALE_HALF_UP && s_shift != '0)
            half_lsb = EXT_W'(1) << (s_shift - SHIFT_W'(1));
        biased = widened + half_lsb;
        scaled = biased >>> s_shift;
        if (scaled > TOP_V)
            clipped = TOP_V[DATA_W-1:0];
        else if (scaled < BOT_V)
            clipped = BOT_V[DATA_W-1:0];
        else
            clipped = scaled[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_valid <= 1'b0;
            o_data  <= '0;
        end else begin
            o_valid <= s_valid;
            if (s_valid)
                o_data <= clipped;
        end
    end

    p_emit_r1: assert property (@(posedge clk) disable iff (rst)
        s_valid |=> o_valid);
    p_floor_sign_r7: assert property (@(posedge clk) disable iff (rst)
        (s_valid && s_mode == SCALE_FLOOR)
        |=> (o_data[DATA_W-1] == $past(s_acc[ACC_W-1])));
    p_unscaled_pass_r2: assert property (@(posedge clk) disable iff (rst)
        (s_valid && s_shift == '0 &&
         s_acc[ACC_W-1:DATA_W-1] == '0)
        |=> (o_data == $past(s_acc[DATA_W-1:0])));

endmodule

// File: rtl/fxp_mac.sv
module fxp_mac
    import fxp_mac_pkg::*;
#(
    parameter int DATA_W  = DEF_DATA_W,
    parameter int GUARD_W = DEF_GUARD_W,
    localparam int ACC_W   = 2 * DATA_W + GUARD_W,
    localparam int SHIFT_W = $clog2(ACC_W)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [DATA_W-1:0]   in_coef,
    input  logic [DATA_W-1:0]   in_samp,
    input  logic                in_clear,
    input  logic                in_sub,
    input  logic                in_frac,
    input  logic [SHIFT_W-1:0]  in_shift,
    input  logic                in_round,
    output logic                out_valid,
    output logic [DATA_W-1:0]   out_data
);
    mac_op_t               op_in;
    logic                  p_valid;
    logic [2*DATA_W-1:0]   p_prod;
    mac_op_t               p_op;
    logic [SHIFT_W-1:0]    p_shift;
    logic                  s_valid;
    logic [ACC_W-1:0]      s_acc;
    logic [SHIFT_W-1:0]    s_shift;
    scale_mode_e           s_mode;

    always_comb begin
        op_in.start = in_clear;
        op_in.neg   = in_sub;
        op_in.dbl   = in_frac;
        op_in.rnd   = in_round;
    end

    fxp_mac_mul #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_mul (
        .clk(clk), .rst(rst),
        .a_valid(in_valid), .a_coef(in_coef), .a_samp(in_samp),
        .a_op(op_in), .a_shift(in_shift),
        .p_valid(p_valid), .p_prod(p_prod), .p_op(p_op), .p_shift(p_shift)
    );

    fxp_mac_acc #(.DATA_W(DATA_W), .GUARD_W(GUARD_W), .SHIFT_W(SHIFT_W)) u_acc (
        .clk(clk), .rst(rst),
        .p_valid(p_valid), .p_prod(p_prod), .p_op(p_op), .p_shift(p_shift),
        .s_valid(s_valid), .s_acc(s_acc), .s_shift(s_shift), .s_mode(s_mode)
    );

    fxp_mac_scale #(.DATA_W(DATA_W), .GUARD_W(GUARD_W), .SHIFT_W(SHIFT_W)) u_scale (
        .clk(clk), .rst(rst),
        .s_valid(s_valid), .s_acc(s_acc), .s_shift(s_shift), .s_mode(s_mode),
        .o_valid(out_valid), .o_data(out_data)
    );

    p_reset_quiet_r11: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));

endmodule

// File: tb/fxp_mac_tb.sv
module fxp_mac_tb;
    localparam int N  = 16;
    localparam int G  = 8;
    localparam int AW = 2 * N + G;
    localparam int SW = $clog2(AW);

    logic clk = 1'b0;
    logic rst;
    logic in_valid, in_clear, in_sub, in_frac, in_round;
    logic [N-1:0] in_coef, in_samp;
    logic [SW-1:0] in_shift;
    logic out_valid;
    logic [N-1:0] out_data;

    int n_checks = 0;
    int n_fails  = 0;
    longint model_acc = 0;

    bit          ev [3];
    logic [N-1:0] ed [3];
    string       et [3];

    always #2 clk = ~clk;   // 250 MHz

    fxp_mac #(.DATA_W(N), .GUARD_W(G)) u_dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_coef(in_coef), .in_samp(in_samp),
        .in_clear(in_clear), .in_sub(in_sub), .in_frac(in_frac),
        .in_shift(in_shift), .in_round(in_round),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [N-1:0] scale_model(input longint acc, input int sh, input bit rnd);
        longint v;
        v = acc;
        if (rnd && sh > 0) v = v + (longint'(1) <<< (sh - 1));
        v = v >>> sh;
        if (v > 32767)  return 16'h7FFF;
        if (v < -32768) return 16'h8000;
        return v[N-1:0];
    endfunction

    task automatic check_out();
        n_checks++;
        if (out_valid !== ev[2] || (ev[2] && out_data !== ed[2])) begin
            n_fails++;
            $display("FAIL %s: out_valid=%0b out_data=%h expected valid=%0b data=%h",
                     et[2], out_valid, out_data, ev[2], ed[2]);
        end
    endtask

    task automatic step(input bit v, input logic [N-1:0] a, input logic [N-1:0] b,
                        input bit clr, input bit sub, input bit frc,
                        input int sh, input bit rnd, input string tag);
        longint p;
        @(negedge clk);
        check_out();
        ev[2] = ev[1]; ed[2] = ed[1]; et[2] = et[1];
        ev[1] = ev[0]; ed[1] = ed[0]; et[1] = et[0];
        ev[0] = v; et[0] = tag; ed[0] = '0;
        if (v) begin
            p = longint'($signed(a)) * longint'($signed(b));
            if (frc) p = p <<< 1;
            if (clr) model_acc = 0;
            model_acc = sub ? model_acc - p : model_acc + p;
            model_acc = (model_acc <<< (64 - AW)) >>> (64 - AW);
            ed[0] = scale_model(model_acc, sh, rnd);
        end
        in_valid = v; in_coef = a; in_samp = b;
        in_clear = clr; in_sub = sub; in_frac = frc;
        in_shift = SW'(sh); in_round = rnd;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1D5E_A7C3));
        for (int i = 0; i < 3; i++) begin ev[i] = 0; ed[i] = '0; et[i] = "R11"; end
        rst = 1'b1;
        in_valid = 0; in_coef = '0; in_samp = '0; in_clear = 0; in_sub = 0;
        in_frac = 0; in_shift = '0; in_round = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11: quiet outputs right after reset
        n_checks++;
        if (out_valid !== 1'b0 || out_data !== '0) begin
            n_fails++;
            $display("FAIL R11: out_valid=%0b out_data=%h expected 0/0000", out_valid, out_data);
        end
        // R11 / R2: first op without clear starts from zero: 3*4 = 12
        step(1, 16'd3, 16'd4, 0, 0, 0, 0, 0, "R11");
        // R2 + R3: fresh sum of 100*-7
        step(1, 16'd100, -16'sd7, 1, 0, 0, 0, 0, "R3");
        // R3 continued accumulation: -700 + 5*6 = -670
        step(1, 16'd5, 16'd6, 0, 0, 0, 0, 0, "R3");
        // R4: subtract 10*10 -> -770
        step(1, 16'd10, 16'd10, 0, 1, 0, 0, 0, "R4");
        // R10: idle cycles with junk controls
        step(0, 16'h7FFF, 16'h7FFF, 1, 1, 1, 5, 1, "R10");
        step(0, 16'h1234, 16'h8000, 1, 0, 0, 9, 0, "R10");
        // R10: add 0 afterwards shows -770 kept
        step(1, 16'd0, 16'd9, 0, 0, 0, 0, 0, "R10");
        // R6: 0.5*0.5 fractional, shift 16 -> 0x2000
        step(1, 16'h4000, 16'h4000, 1, 0, 1, 16, 0, "R6");
        // R7/R8: acc = 3
        step(1, 16'd1, 16'd3, 1, 0, 0, 1, 1, "R8");
        step(1, 16'd0, 16'd0, 0, 0, 0, 1, 0, "R7");
        step(1, 16'd0, 16'd0, 0, 0, 0, 0, 1, "R8");
        // acc = -3
        step(1, 16'd1, 16'd3, 1, 1, 0, 1, 1, "R8");
        step(1, 16'd0, 16'd0, 0, 0, 0, 1, 0, "R7");
        // R9: saturation both rails
        step(1, 16'h7FFF, 16'h7FFF, 1, 0, 0, 0, 0, "R9");
        step(1, 16'h7FFF, 16'h8000, 1, 0, 0, 0, 1, "R9");
        step(1, 16'h8000, 16'h8000, 1, 0, 1, 3, 0, "R9");
        // R5: 200 x (-32768 * -32768), shift 24
        for (int k = 0; k < 200; k++)
            step(1, 16'h8000, 16'h8000, k == 0, 0, 0, 24, 0, "R5");
        // R1: random back-to-back stream with gaps
        for (int k = 0; k < 3000; k++) begin
            bit v;
            v = ($urandom() % 4) != 0;
            step(v, N'($urandom()), N'($urandom()), ($urandom() % 12) == 0,
                 $urandom() % 2, $urandom() % 2, $urandom_range(0, AW - 1),
                 $urandom() % 2, "R1");
        end
        for (int k = 0; k < 4; k++)
            step(0, '0, '0, 0, 0, 0, 0, 0, "R1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule